// File: doc/BRIEF.md
# Serial Frequency-Word Configuration Port

This block is the configuration front end of an integer-N frequency synthesizer. A slow three-wire serial port (data, serial clock, strobe) plus a handful of steering lines loads one of three shift registers: a 20-bit staging word, a 20-bit non-volatile shadow word, or an 8-bit option byte. Bits arrive least significant first and are taken on rising edges of the serial clock. Every pin is sampled by a fast system clock through a synchronizer, and edges are detected on the synchronized serial clock and strobe.

The staging word is double-buffered. It reaches the divider only when a rising strobe edge copies it into a 20-bit active word, so a new word can be shifted in while the old one keeps driving. A select line chooses whether the divider sees the active word or the shadow word. The option byte is visible only while an active-low enable is held low. The shadow word can be read back serially: in readback mode each serial clock rotates it by one place and presents its lowest bit on the serial output, so the stored value is restored after 20 clocks.

Top module: `pll_serial_cfg`

## Requirements
- R1: A synchronous active-low reset clears the staging, active, shadow and option registers, so that freq_word, opt_bits and sdo are all 0 for either value of sel_shadow.
- R2: With opt_we=0 and shadow_ld=0, each serial clock rising edge shifts sdata into the staging word least significant bit first: the new bit enters bit 19 and the word moves one place toward bit 0. After more than 20 clocks only the last 20 bits remain, with the first of those at bit 0.
- R3: The active word changes only on a rising edge of strobe, which copies the whole staging word into it. Shifting without a strobe leaves freq_word unchanged while sel_shadow=0.
- R4: With opt_we=0, shadow_ld=1 and strobe=0, serial clocks shift sdata into the shadow word in the same LSB-first order as R2. The staging word is not changed.
- R5: freq_word equals the active word when sel_shadow=0 and the shadow word when sel_shadow=1.
- R6: The option byte shifts LSB first (the new bit enters bit 7) only while opt_we=1. opt_we takes priority over every other steering line, and the staging and shadow words are then left unchanged.
- R7: opt_bits equals the option byte while opt_en_n=0 and is all zeros while opt_en_n=1.
- R8: With opt_we=0, shadow_ld=1 and strobe=1, each serial clock rotates the shadow word one place toward bit 0, bit 0 wrapping to bit 19. sdo always shows shadow bit 0. Reading 20 clocks therefore gives the word LSB first and leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdata | input | 1 | Serial data |
| sclk | input | 1 | Serial clock; rising edges shift |
| strobe | input | 1 | Rising edge copies staging to active word |
| opt_we | input | 1 | Option byte write enable |
| shadow_ld | input | 1 | Steers serial data to the shadow word |
| sel_shadow | input | 1 | 1 selects the shadow word for freq_word |
| opt_en_n | input | 1 | Active-low enable for opt_bits |
| sdo | output | 1 | Serial readback of shadow bit 0 |
| freq_word | output | 20 | Word presented to the divider |
| opt_bits | output | 8 | Gated option byte |

## Verification
Every pin passes through two synchronizer flops, and one more register holds the last edge-detector value. An edge on sclk or strobe therefore reaches a register three system clocks after the pin changes, while a change of sel_shadow or opt_en_n reaches the outputs after two. The bench drives on falling clock edges and holds each serial clock phase and each strobe phase for four system clocks. It samples only after that hold, so every result has settled before it is compared. In readback it samples sdo before each rising serial edge, and the sweeps over staging, shadow and option values are checked against a model that the bench shifts itself.

// File: rtl/pll_serial_cfg.sv
module pll_serial_cfg #(
  parameter int FREQ_W      = 20,
  parameter int OPT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              sclk,
  input  logic              strobe,
  input  logic              opt_we,
  input  logic              shadow_ld,
  input  logic              sel_shadow,
  input  logic              opt_en_n,
  output logic              sdo,
  output logic [FREQ_W-1:0] freq_word,
  output logic [OPT_W-1:0]  opt_bits
);

  localparam int NIN = 7;

  logic [NIN-1:0] pins;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] pins_s;

  assign pins   = {opt_en_n, sel_shadow, shadow_ld, opt_we, strobe, sdata, sclk};
  assign pins_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic sclk_s, sdata_s, strobe_s, opt_we_s, shadow_ld_s, sel_s, opt_en_n_s;
  assign {opt_en_n_s, sel_s, shadow_ld_s, opt_we_s, strobe_s, sdata_s, sclk_s} = pins_s;

  logic sclk_d, strobe_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      strobe_d <= strobe_s;
    end
  end

  logic sclk_rise, strobe_rise, rb_mode;
  assign sclk_rise   = sclk_s & ~sclk_d;
  assign strobe_rise = strobe_s & ~strobe_d;
  assign rb_mode     = ~opt_we_s & shadow_ld_s & strobe_s;

  logic [FREQ_W-1:0] staging, active, shadow;
  logic [OPT_W-1:0]  opt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staging <= '0;
      shadow  <= '0;
      opt_q   <= '0;
    end else if (sclk_rise) begin
      if (opt_we_s)
        opt_q <= {sdata_s, opt_q[OPT_W-1:1]};
      else if (rb_mode)
        shadow <= {shadow[0], shadow[FREQ_W-1:1]};
      else if (shadow_ld_s)
        shadow <= {sdata_s, shadow[FREQ_W-1:1]};
      else
        staging <= {sdata_s, staging[FREQ_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           active <= '0;
    else if (strobe_rise) active <= staging;
  end

  assign sdo       = shadow[0];
  assign freq_word = sel_s ? shadow : active;
  assign opt_bits  = opt_en_n_s ? '0 : opt_q;

endmodule

module pll_serial_cfg_chk #(
  parameter int FREQ_W = 20,
  parameter int OPT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opt_en_n,
  input logic [OPT_W-1:0]  opt_bits,
  input logic              sdo,
  input logic [FREQ_W-1:0] freq_word,
  input logic              sclk_rise,
  input logic              strobe_rise,
  input logic              opt_we_s,
  input logic              rb_mode,
  input logic [FREQ_W-1:0] active,
  input logic [FREQ_W-1:0] shadow,
  input logic [OPT_W-1:0]  opt_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (freq_word == '0 && opt_bits == '0 && sdo == 1'b0));

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(active));

  assert_opt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && opt_we_s) |=> $stable(opt_q));

  assert_opt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_en_n && $past(opt_en_n) && $past(opt_en_n, 2)) |-> opt_bits == '0);

  assert_rotate_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && rb_mode) |=> $countones(shadow) == $countones($past(shadow)));

endmodule

bind pll_serial_cfg pll_serial_cfg_chk #(.FREQ_W(FREQ_W), .OPT_W(OPT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opt_en_n(opt_en_n), .opt_bits(opt_bits),
  .sdo(sdo), .freq_word(freq_word), .sclk_rise(sclk_rise),
  .strobe_rise(strobe_rise), .opt_we_s(opt_we_s), .rb_mode(rb_mode),
  .active(active), .shadow(shadow), .opt_q(opt_q)
);

// File: tb/pll_serial_cfg_test.sv
module pll_serial_cfg_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 20;
  localparam int OW = 8;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0, sdata = 0, sclk = 0, strobe = 0;
  logic opt_we = 0, shadow_ld = 0, sel_shadow = 0, opt_en_n = 1;
  logic sdo;
  logic [FW-1:0] freq_word;
  logic [OW-1:0] opt_bits;

  int checks = 0, failures = 0;
  logic [FW-1:0] m_stg = 0, m_act = 0, m_sh = 0;
  logic [OW-1:0] m_opt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_serial_cfg uut (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .strobe(strobe),
    .opt_we(opt_we), .shadow_ld(shadow_ld), .sel_shadow(sel_shadow),
    .opt_en_n(opt_en_n), .sdo(sdo), .freq_word(freq_word), .opt_bits(opt_bits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdata = b;
    wait_clk(HOLD);
    sclk = 1;
    wait_clk(HOLD);
    sclk = 0;
    if (opt_we) m_opt = {b, m_opt[OW-1:1]};
    else if (shadow_ld && strobe) m_sh = {m_sh[0], m_sh[FW-1:1]};
    else if (shadow_ld) m_sh = {b, m_sh[FW-1:1]};
    else m_stg = {b, m_stg[FW-1:1]};
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) pulse(v[i]);
    wait_clk(HOLD);
  endtask

  task automatic strobe_pulse();
    strobe = 1;
    wait_clk(HOLD);
    m_act = m_stg;
    strobe = 0;
    wait_clk(HOLD);
  endtask

  task automatic set_sel(input logic v);
    sel_shadow = v;
    wait_clk(HOLD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(4);
    chk("R1 freq after reset", freq_word, 0);
    chk("R1 sdo after reset", sdo, 0);
    rst_n = 1;
    wait_clk(4);
    chk("R1 opt after reset", opt_bits, 0);
    set_sel(1);
    chk("R1 shadow after reset", freq_word, 0);
    set_sel(0);

    for (int k = 0; k < FW; k++) begin
      send(32'h1 << k, FW);
      chk("R3 no change before strobe", freq_word, m_act);
      strobe_pulse();
      chk("R2 R3 walking one staging", freq_word, 32'h1 << k);
    end

    send(32'hABCDE, FW);
    strobe_pulse();
    chk("R2 pattern", freq_word, 32'hABCDE);
    send(32'hF5A3C1, 24);
    strobe_pulse();
    chk("R2 overlength keeps last 20", freq_word, 32'hF5A3C);
    chk("R2 model agrees", freq_word, m_act);

    shadow_ld = 1;
    wait_clk(HOLD);
    for (int k = 0; k < FW; k += 3) begin
      send(32'h1 << k, FW);
      set_sel(1);
      chk("R4 R5 shadow walking one", freq_word, 32'h1 << k);
      set_sel(0);
      chk("R4 R5 active untouched", freq_word, m_act);
    end
    send(32'h5C3A9, FW);
    shadow_ld = 0;
    wait_clk(HOLD);
    strobe_pulse();
    chk("R4 staging untouched by shadow load", freq_word, 32'hF5A3C);

    opt_en_n = 0;
    opt_we = 1;
    wait_clk(HOLD);
    for (int v = 0; v < 256; v++) begin
      send(v, OW);
      chk("R6 option byte", opt_bits, v);
    end
    send(32'h96, OW);
    opt_en_n = 1;
    wait_clk(3);
    chk("R7 gated off", opt_bits, 0);
    opt_en_n = 0;
    wait_clk(3);
    chk("R7 gated on", opt_bits, 8'h96);
    shadow_ld = 1;
    wait_clk(HOLD);
    send(32'h3C, OW);
    shadow_ld = 0;
    opt_we = 0;
    wait_clk(HOLD);
    chk("R6 priority over shadow", opt_bits, 8'h3C);
    set_sel(1);
    chk("R6 shadow untouched", freq_word, 32'h5C3A9);
    set_sel(0);
    strobe_pulse();
    chk("R6 staging untouched", freq_word, 32'hF5A3C);

    shadow_ld = 1;
    wait_clk(HOLD);
    strobe = 1;
    m_act = m_stg;
    wait_clk(HOLD);
    for (int i = 0; i < FW; i++) begin
      chk("R8 readback bit", sdo, m_sh[0]);
      chk("R8 readback order", sdo, (32'h5C3A9 >> i) & 1);
      pulse(1'b0);
    end
    wait_clk(HOLD);
    strobe = 0;
    wait_clk(HOLD);
    shadow_ld = 0;
    wait_clk(HOLD);
    set_sel(1);
    chk("R8 preserved after 20", freq_word, 32'h5C3A9);
    set_sel(0);

    rst_n = 0;
    wait_clk(2);
    rst_n = 1;
    m_stg = 0; m_act = 0; m_sh = 0; m_opt = 0;
    wait_clk(2);
    chk("R1 mid-run reset active", freq_word, 0);
    chk("R1 mid-run reset opt", opt_bits, 0);
    chk("R1 mid-run reset sdo", sdo, 0);
    set_sel(1);
    chk("R1 mid-run reset shadow", freq_word, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule